// File: doc/BRIEF.md
# Parallel Reed-Solomon Syndrome Calculator

This block takes a received Reed-Solomon word over GF(2^8) and computes its 2t syndromes, one per evaluation point alpha^(m0+i). The symbols arrive highest degree first, accompanied by a valid strobe and a start-of-word strobe. Each syndrome has its own multiply-accumulate cell. The cell applies Horner's rule through a multiplier whose second operand is a fixed field constant. A field addition is a plain 8-bit XOR.

A parameter sets how many symbols enter on each clock. With one lane, every valid beat multiplies the accumulator by alpha^(m0+i) and adds the new symbol, so a 255-symbol word takes 255 beats. With more than one lane, the work is split into two stages. A first Horner stage folds the lanes of a beat into a partial value. A second stage scales the accumulator by alpha^((m0+i)*lanes) and adds that partial value. The default code is (255,239), which gives 16 syndromes, with m0 = 0 and the field polynomial x^8+x^4+x^3+x^2+1.

When the last beat of a word has been taken, a done pulse lasts one cycle. In that cycle the syndrome outputs hold the word's result, and a flag reports whether every syndrome is zero. A start-of-word beat loads the accumulators directly. Words can therefore follow one another with no idle cycle between them.

Top module: `rs_syndrome_par`

## Requirements
- R1: With one lane, syndrome i (output bits [8i+7:8i]) equals the received polynomial evaluated at alpha^(m0+i). Here alpha is the element 0x02 of the field built from polynomial 0x11D, and the first symbol of a word is the coefficient of the highest degree.
- R2: done_o is high for exactly one cycle, and that cycle directly follows the clock edge that takes the last beat of a word. Only complete words produce a pulse.
- R3: While done_o is high, zero_o is 1 if all syndromes are zero and 0 if any syndrome is nonzero. zero_o is 0 whenever done_o is 0.
- R4: A beat with in_valid=1 and in_sof=1 starts a new word and ignores earlier accumulator contents. Words sent back-to-back, with the start beat in the cycle right after the previous last beat, each give correct syndromes in their own done cycle.
- R5: Cycles with in_valid=0 are ignored whatever in_sym carries. Idle cycles inside a word leave the result unchanged, and between words the syndrome outputs hold their value.
- R6: With LANES>1, a word of CODE_N symbols enters in CODE_N/LANES beats. Lane 0 (bits [7:0]) carries the highest-degree symbol of the beat. The syndromes equal those of the same word entered one symbol at a time.
- R7: After reset, done_o and zero_o are 0 and all syndrome outputs are zero.
- R8: A start-of-word beat in the middle of a word drops the partial word. No done pulse is given for the dropped part, and the new word is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | The beat on in_sym is valid |
| in_sof | input | 1 | The beat is the first beat of a word |
| in_sym | input | 8*LANES | Received symbols; lane 0 is the highest degree |
| syn_o | output | 8*NSYN | Syndromes; syndrome i at bits [8i+7:8i] |
| done_o | output | 1 | One-cycle pulse: syndromes of a complete word are present |
| zero_o | output | 1 | With done_o: all syndromes are zero |

## Verification
A word's done cycle can be the same cycle in which the next word's start beat is presented. In that cycle the outputs must still show the finished word while the cells take in the new word. The bench sends words back-to-back in this way, and it also restarts a word in the middle with a fresh start beat. A monitor compares the syndromes and the zero flag in every done cycle against values the bench computes itself, and it checks that the number of done pulses equals the number of complete words sent.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int SYM_W   = 8;
  localparam int FIELD_N = 255;
  localparam logic [SYM_W-1:0] POLY_LO = 8'h1D;  // x^8+x^4+x^3+x^2+1

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [2*SYM_W-2:0] prod;
    prod = '0;
    for (int i = 0; i < SYM_W; i++)
      if (b[i]) prod = prod ^ ({{(SYM_W-1){1'b0}}, a} << i);
    for (int k = 2*SYM_W-2; k >= SYM_W; k--)
      if (prod[k]) prod = prod ^ ({{(SYM_W-1){1'b0}}, 1'b1, POLY_LO} << (k - SYM_W));
    return prod[SYM_W-1:0];
  endfunction

  function automatic logic [SYM_W-1:0] gf_pow(input int e);
    logic [SYM_W-1:0] r;
    r = 8'h01;
    for (int k = 0; k < (e % FIELD_N); k++) r = gf_mul(r, 8'h02);
    return r;
  endfunction
endpackage

// File: rtl/gf_cmul.sv
module gf_cmul
  import rs_syn_pkg::*;
#(
  parameter logic [SYM_W-1:0] COEF = 8'h02
) (
  input  logic [SYM_W-1:0] x,
  output logic [SYM_W-1:0] y
);
  always_comb y = gf_mul(x, COEF);
endmodule

// File: rtl/rs_beat_ctl.sv
module rs_beat_ctl #(
  parameter int BEATS = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  output logic first_o,
  output logic done_o
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             done_q, done_nxt;
  logic             first, last;

  always_comb begin
    first    = in_valid && (in_sof || cnt_q == '0);
    last     = in_valid && (first ? (BEATS == 1) : (cnt_q == LAST));
    cnt_nxt  = cnt_q;
    if (in_valid) begin
      if (last)       cnt_nxt = '0;
      else if (first) cnt_nxt = CNT_W'(1);
      else            cnt_nxt = cnt_q + 1'b1;
    end
    done_nxt = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (in_valid) cnt_q <= cnt_nxt;
      done_q <= done_nxt;
    end
  end

  assign first_o = first;
  assign done_o  = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && BEATS > 1) |=> !done_q); // R2
  AST_DONE_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(in_valid)); // R2
endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int EXP   = 0,
  parameter int LANES = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   first,
  input  logic [LANES*SYM_W-1:0] in_sym,
  output logic [SYM_W-1:0]       syn_o
);
  localparam logic [SYM_W-1:0] ROOT  = gf_pow(EXP);
  localparam logic [SYM_W-1:0] BSTEP = gf_pow(EXP * LANES);

  logic [SYM_W-1:0] part;
  logic [SYM_W-1:0] acc_q, acc_nxt, acc_scaled;

  // stage one: fold the lanes of one beat, lane 0 highest degree
  generate
    if (LANES == 1) begin : g_single
      assign part = in_sym[SYM_W-1:0];
    end else begin : g_multi
      logic [SYM_W-1:0] chain  [LANES];
      logic [SYM_W-1:0] scaled [LANES];
      assign chain[0]  = in_sym[SYM_W-1:0];
      assign scaled[0] = '0;
      for (genvar j = 1; j < LANES; j++) begin : g_lane
        gf_cmul #(.COEF(ROOT)) u_mul (.x(chain[j-1]), .y(scaled[j]));
        assign chain[j] = scaled[j] ^ in_sym[j*SYM_W +: SYM_W];
      end
      assign part = chain[LANES-1];
    end
  endgenerate

  // stage two: accumulate beats
  gf_cmul #(.COEF(BSTEP)) u_step (.x(acc_q), .y(acc_scaled));

  always_comb acc_nxt = first ? part : (acc_scaled ^ part);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (in_valid) acc_q <= acc_nxt;
  end

  assign syn_o = acc_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q)); // R5
endmodule

// File: rtl/rs_syndrome_par.sv
module rs_syndrome_par
  import rs_syn_pkg::*;
#(
  parameter int CODE_N = 255,
  parameter int NSYN   = 16,
  parameter int M0     = 0,
  parameter int LANES  = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [LANES*SYM_W-1:0] in_sym,
  output logic [NSYN*SYM_W-1:0]  syn_o,
  output logic                   done_o,
  output logic                   zero_o
);
  localparam int BEATS = CODE_N / LANES;

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       first, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  rs_beat_ctl #(.BEATS(BEATS)) u_ctl (
    .clk(clk), .rst_n(rst_s), .in_valid(in_valid), .in_sof(in_sof),
    .first_o(first), .done_o(done)
  );

  generate
    for (genvar i = 0; i < NSYN; i++) begin : g_cell
      rs_syn_cell #(.EXP(M0 + i), .LANES(LANES)) u_cell (
        .clk(clk), .rst_n(rst_s), .in_valid(in_valid), .first(first),
        .in_sym(in_sym), .syn_o(syn_o[i*SYM_W +: SYM_W])
      );
    end
  endgenerate

  assign done_o = done;
  assign zero_o = done && (syn_o == '0);

  AST_ZERO_QUAL: assert property (@(posedge clk) disable iff (!rst_s)
    zero_o |-> done_o); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s |-> (!done_o && !zero_o)); // R7
endmodule

// File: tb/rs_syndrome_par_test.sv
module rs_syndrome_par_test;
  localparam int N  = 255;
  localparam int NS = 16;
  localparam int WL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          vn = 0, sn = 0, vw = 0, sw = 0;
  logic [7:0]    dn = 0;
  logic [8*WL-1:0] dw = 0;
  logic [8*NS-1:0] syn_n, syn_w;
  logic          done_n, zero_n, done_w, zero_w;

  rs_syndrome_par #(.CODE_N(N), .NSYN(NS), .M0(0), .LANES(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(vn), .in_sof(sn), .in_sym(dn),
    .syn_o(syn_n), .done_o(done_n), .zero_o(zero_n));

  rs_syndrome_par #(.CODE_N(N), .NSYN(NS), .M0(0), .LANES(WL)) uut_w (
    .clk(clk), .rst_n(rst_n), .in_valid(vw), .in_sof(sw), .in_sym(dw),
    .syn_o(syn_w), .done_o(done_w), .zero_o(zero_w));

  int checks = 0, errors = 0;
  logic [7:0]      w [N];
  logic [8*NS-1:0] expn [64];
  logic [8*NS-1:0] expw [64];
  int pn = 0, cn = 0, pw = 0, cw = 0;
  logic prev_dn = 0, prev_dw = 0;
  int cyc = 0;

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 0; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [8*NS-1:0] ref_syn();
    logic [8*NS-1:0] r;
    logic [7:0] root, acc;
    root = 8'h01;
    for (int i = 0; i < NS; i++) begin
      acc = 0;
      for (int k = 0; k < N; k++) acc = bmul(acc, root) ^ w[k];
      r[8*i +: 8] = acc;
      root = bmul(root, 8'h02);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [8*NS-1:0] act,
                       input logic [8*NS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitors sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_n) begin
        if (cn >= pn) check(0, "R2 spurious done (1 lane)", 1, 0);
        else begin
          check(syn_n == expn[cn], "R1/R4 syndromes (1 lane)", syn_n, expn[cn]);
          check(zero_n == (expn[cn] == 0), "R3 zero flag (1 lane)", zero_n, expn[cn] == 0);
          cn++;
        end
        if (prev_dn) check(0, "R2 done longer than one cycle (1 lane)", 1, 0);
      end else if (zero_n) check(0, "R3 zero without done (1 lane)", 1, 0);
      if (done_w) begin
        if (cw >= pw) check(0, "R2 spurious done (lanes)", 1, 0);
        else begin
          check(syn_w == expw[cw], "R6 syndromes (lanes)", syn_w, expw[cw]);
          check(zero_w == (expw[cw] == 0), "R3 zero flag (lanes)", zero_w, expw[cw] == 0);
          cw++;
        end
        if (prev_dw) check(0, "R2 done longer than one cycle (lanes)", 1, 0);
      end else if (zero_w) check(0, "R3 zero without done (lanes)", 1, 0);
    end
    prev_dn <= done_n;
    prev_dw <= done_w;
  end

  task automatic send(input int lanes, input int nsym, input bit gaps);
    if (nsym == N) begin
      if (lanes == 1) begin expn[pn % 64] = ref_syn(); pn++; end
      else            begin expw[pw % 64] = ref_syn(); pw++; end
    end
    for (int b = 0; b < nsym / lanes; b++) begin
      @(negedge clk);
      if (lanes == 1) begin
        vn = 1; sn = (b == 0); dn = w[b];
      end else begin
        vw = 1; sw = (b == 0);
        for (int j = 0; j < WL; j++) dw[8*j +: 8] = w[b*WL + j];
      end
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        vn = 0; vw = 0; sn = $urandom; sw = $urandom;
        dn = $urandom; dw = $urandom;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vn = 0; vw = 0; sn = 0; sw = 0; dn = $urandom; dw = $urandom;
    end
  endtask

  task automatic fill_rand();
    for (int k = 0; k < N; k++) w[k] = $urandom;
  endtask

  task automatic run_set(input int lanes);
    logic [8*NS-1:0] hold;
    fill_rand(); send(lanes, N, 0); idle(3);           // R1 / R6 plain
    fill_rand(); send(lanes, N, 1); idle(2);           // R5 gaps inside a word
    for (int k = 0; k < N; k++) w[k] = 0;
    send(lanes, N, 0); idle(2);                        // R3 all-zero word
    w[N-7] = 8'h5A; send(lanes, N, 0); idle(2);        // R3 single error, nonzero
    for (int k = 0; k < N; k++) w[k] = 8'hFF;
    send(lanes, N, 0);                                 // R4 back-to-back chain
    fill_rand(); send(lanes, N, 0);
    fill_rand(); send(lanes, N, 0); idle(2);
    fill_rand(); send(lanes, 99, 0);                   // R8 dropped partial word
    fill_rand(); send(lanes, N, 0); idle(2);
    hold = (lanes == 1) ? syn_n : syn_w;
    idle(5);                                           // R5 hold between words
    check(((lanes == 1) ? syn_n : syn_w) == hold, "R5 outputs hold while idle",
          (lanes == 1) ? syn_n : syn_w, hold);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(syn_n == 0 && !done_n && !zero_n, "R7 reset state (1 lane)", syn_n, 0);
    check(syn_w == 0 && !done_w && !zero_w, "R7 reset state (lanes)", syn_w, 0);
    run_set(1);
    run_set(WL);
    idle(3);
    check(cn == pn, "R2 done count equals words (1 lane)", cn, pn);
    check(cw == pw, "R2 done count equals words (lanes)", cw, pw);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule